// File: doc/BRIEF.md
# Packet Filter Interrupt Sequencer

This controller sits between an external Ethernet MAC chip and a host. The MAC's register bus has no ready handshake. When the MAC raises its interrupt line, the sequencer takes over the bus. It first saves the MAC's interrupt mask and data pointer, then silences the mask and reads the interrupt status to learn whether a frame arrived or was sent. It reads the frame's Ethertype, works out where the relevant IPv4 address sits, and fetches that 32-bit address so an external trusted-address lookup can judge it. It then puts the MAC back as it found it. A host interrupt is raised only for a received frame whose sender passed the lookup.

Every read of frame data is preceded by a pointer write and a fixed wait of `WAIT_CYC` clock cycles in a shared wait state. The wait stands in for the missing ready signal. With the default of 12 cycles and one cycle to enter the state, each read comes 13 cycles after its pointer write, which covers a 370 ns fill time at a 30 ns clock. The wait state and the Ethertype step are both shared. Each remembers its caller in a return register and goes back to it when done.

Top module: `pkt_irq_seq`

## Requirements
- R1: After reset the block performs no bus access, and `host_irq` and `ip_valid` are low until `chip_irq` is seen.
- R2: When `chip_irq` is high in idle, the block performs these bus accesses in order: read the mask register, write 0 to the mask register, read the pointer register, read the status register.
- R3: Status bit 0 means a frame was received and bit 1 means a frame was sent. Bit 0 wins when both are set. When neither is set, the block goes straight to the restore steps with no frame access.
- R4: A pointer write carries bit 15 = 1 to select receive memory or 0 to select transmit memory, and the byte offset in bits 10:0. The first pointer write of a service has offset 12, the Ethertype.
- R5: Every read of the data register comes exactly `WAIT_CYC`+1 cycles after the last pointer write. It is never sooner.
- R6: An Ethertype of 0x0800 is IPv4 and 0x0806 is ARP. Any other value skips the address reads and goes directly to restore.
- R7: The address offset (`ip_off`) is 26 for received IPv4, 30 for sent IPv4, 28 for received ARP and 38 for sent ARP.
- R8: The address is read as two words, at the offset and at the offset + 2. `ip_addr` = {first word, second word}. It is presented with `ip_valid` high for one cycle, and `trust_ok` is sampled in that cycle.
- R9: Restore writes the status register with the serviced cause bit (0 if there was no cause), then writes back the saved pointer, then writes back the saved mask.
- R10: `host_irq` is a one-cycle pulse, given in the same cycle as the final mask write. It is given only for a received frame whose lookup returned `trust_ok`, and never for a sent frame.
- R11: Restore clears the accept flag, `ip_addr` and `ip_off`, so one service does not influence the next.
- R12: The block never drives a read and a write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chip_irq | input | 1 | Interrupt request from the MAC chip |
| bus_addr | output | AW | Register address on the chip bus |
| bus_rd | output | 1 | Read strobe; `bus_rdata` is taken in the same cycle |
| bus_wr | output | 1 | Write strobe |
| bus_wdata | output | 16 | Write data |
| bus_rdata | input | 16 | Read data from the chip |
| ip_addr | output | 32 | Fetched IPv4 address |
| ip_off | output | 11 | Byte offset the address was read from |
| ip_valid | output | 1 | One-cycle strobe: address is ready for lookup |
| trust_ok | input | 1 | Lookup verdict, sampled while `ip_valid` is high |
| host_irq | output | 1 | Packet-accepted interrupt to the host |

## Verification
The bench runs all four combinations of direction and protocol, because a swapped offset would fetch the wrong address and let an untrusted sender through. It also covers an unknown Ethertype, which must skip the address reads; a status word with no cause bit; and a status word with both bits set, where serving the sent frame first would acknowledge the wrong bit and leave the MAC's status wrong. Every data read is timed against its pointer write, so a wait counter that is off by one would show up as an early read. A trusted receive followed by an untrusted one, and a trusted send, catch an accept flag that stays set or that is not gated by direction.

// File: rtl/pkf_pkg.sv
package pkf_pkg;

  localparam int DW    = 16;
  localparam int OFF_W = 11;

  localparam logic [DW-1:0] ETY_IPV4 = 16'h0800;
  localparam logic [DW-1:0] ETY_ARP  = 16'h0806;

  localparam logic [OFF_W-1:0] OFF_ETYPE   = 11'd12;
  localparam logic [OFF_W-1:0] OFF_RX_IPV4 = 11'd26;
  localparam logic [OFF_W-1:0] OFF_TX_IPV4 = 11'd30;
  localparam logic [OFF_W-1:0] OFF_RX_ARP  = 11'd28;
  localparam logic [OFF_W-1:0] OFF_TX_ARP  = 11'd38;

  typedef enum logic [4:0] {
    S_IDLE,
    S_SAVE_MASK,
    S_MASK_OFF,
    S_SAVE_PTR,
    S_RD_STAT,
    S_RX_SVC,
    S_TX_SVC,
    S_ETY_PTR,
    S_PF_WAIT,
    S_ETY_DATA,
    S_HI_PTR,
    S_HI_RD,
    S_LO_PTR,
    S_LO_RD,
    S_LOOKUP,
    S_RST_ACK,
    S_RST_PTR,
    S_RST_MASK
  } seq_state_t;

endpackage

// File: rtl/pkf_wait_timer.sv
module pkf_wait_timer #(
  parameter int WAIT_CYC = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic done
);
  localparam int CW = (WAIT_CYC < 2) ? 1 : $clog2(WAIT_CYC + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (start) begin
      cnt_en = 1'b1;
      cnt_d  = CW'(WAIT_CYC - 1);
    end else if (cnt_q != '0) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign done = (cnt_q == '0);

  AST_WAIT_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
    (start && WAIT_CYC > 1) |=> !done) else $error("wait ended early"); // R5

endmodule

// File: rtl/pkf_type_locator.sv
module pkf_type_locator
  import pkf_pkg::*;
(
  input  logic [DW-1:0]    ethertype,
  input  logic             rx_side,
  output logic [OFF_W-1:0] addr_off,
  output logic             bad_type
);
  always_comb begin
    bad_type = 1'b0;
    addr_off = '0;
    unique case (ethertype)
      ETY_IPV4: addr_off = rx_side ? OFF_RX_IPV4 : OFF_TX_IPV4;
      ETY_ARP:  addr_off = rx_side ? OFF_RX_ARP  : OFF_TX_ARP;
      default:  bad_type = 1'b1;
    endcase
  end
endmodule

// File: rtl/pkf_ctx_store.sv
module pkf_ctx_store
  import pkf_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          save_mask,
  input  logic          save_ptr,
  input  logic          save_cause,
  input  logic          clr,
  input  logic [DW-1:0] din,
  input  logic [1:0]    cause_in,
  output logic [DW-1:0] mask_q,
  output logic [DW-1:0] ptr_q,
  output logic [1:0]    cause_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (clr) begin
      mask_q <= '0;
    end else if (save_mask) begin
      mask_q <= din;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (clr) begin
      ptr_q <= '0;
    end else if (save_ptr) begin
      ptr_q <= din;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause_q <= '0;
    end else if (clr) begin
      cause_q <= '0;
    end else if (save_cause) begin
      cause_q <= cause_in;
    end
  end

  AST_CAUSE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cause_q)) else $error("two causes served at once"); // R3

endmodule

// File: rtl/pkt_irq_seq.sv
module pkt_irq_seq
  import pkf_pkg::*;
#(
  parameter int              AW       = 4,
  parameter int              WAIT_CYC = 12,
  parameter logic [AW-1:0]   A_STAT   = 4'd0,
  parameter logic [AW-1:0]   A_MASK   = 4'd1,
  parameter logic [AW-1:0]   A_PTR    = 4'd2,
  parameter logic [AW-1:0]   A_DATA   = 4'd3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             chip_irq,
  output logic [AW-1:0]    bus_addr,
  output logic             bus_rd,
  output logic             bus_wr,
  output logic [15:0]      bus_wdata,
  input  logic [15:0]      bus_rdata,
  output logic [31:0]      ip_addr,
  output logic [10:0]      ip_off,
  output logic             ip_valid,
  input  logic             trust_ok,
  output logic             host_irq
);
  localparam int GAP_LIM = WAIT_CYC + 1;
  localparam int GW      = $clog2(GAP_LIM + 1) + 1;

  seq_state_t state_q, state_d;
  seq_state_t pf_ret_q, pf_ret_d;
  seq_state_t ety_ret_q, ety_ret_d;

  logic             ety_done_q, ety_done_d;
  logic             ety_err_q, ety_err_d;
  logic             accept_q, accept_d;
  logic [OFF_W-1:0] off_q, off_d;
  logic [DW-1:0]    hi_q, hi_d, lo_q, lo_d;

  logic             pf_start, pf_done;
  logic             save_mask, save_ptr, save_cause, ctx_clr;
  logic [1:0]       cause_in, cause_q;
  logic [DW-1:0]    mask_q, ptr_q;
  logic             loc_rx;
  logic [OFF_W-1:0] loc_off;
  logic             loc_bad;
  logic             dir_rx;

  assign dir_rx = cause_q[0];
  assign loc_rx = (ety_ret_q == S_RX_SVC);

  pkf_wait_timer #(.WAIT_CYC(WAIT_CYC)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .start (pf_start),
    .done  (pf_done)
  );

  pkf_type_locator u_loc (
    .ethertype (bus_rdata),
    .rx_side   (loc_rx),
    .addr_off  (loc_off),
    .bad_type  (loc_bad)
  );

  pkf_ctx_store u_ctx (
    .clk        (clk),
    .rst_n      (rst_n),
    .save_mask  (save_mask),
    .save_ptr   (save_ptr),
    .save_cause (save_cause),
    .clr        (ctx_clr),
    .din        (bus_rdata),
    .cause_in   (cause_in),
    .mask_q     (mask_q),
    .ptr_q      (ptr_q),
    .cause_q    (cause_q)
  );

  function automatic logic [DW-1:0] ptr_word(input logic rx, input logic [OFF_W-1:0] off);
    return {rx, 4'b0000, off};
  endfunction

  always_comb begin
    state_d    = state_q;
    pf_ret_d   = pf_ret_q;
    ety_ret_d  = ety_ret_q;
    ety_done_d = ety_done_q;
    ety_err_d  = ety_err_q;
    accept_d   = accept_q;
    off_d      = off_q;
    hi_d       = hi_q;
    lo_d       = lo_q;
    bus_addr   = '0;
    bus_rd     = 1'b0;
    bus_wr     = 1'b0;
    bus_wdata  = '0;
    pf_start   = 1'b0;
    save_mask  = 1'b0;
    save_ptr   = 1'b0;
    save_cause = 1'b0;
    ctx_clr    = 1'b0;
    cause_in   = 2'b00;
    ip_valid   = 1'b0;
    host_irq   = 1'b0;

    unique case (state_q)
      S_IDLE: if (chip_irq) state_d = S_SAVE_MASK;
      S_SAVE_MASK: begin
        bus_rd = 1'b1; bus_addr = A_MASK; save_mask = 1'b1;
        state_d = S_MASK_OFF;
      end
      S_MASK_OFF: begin
        bus_wr = 1'b1; bus_addr = A_MASK;
        state_d = S_SAVE_PTR;
      end
      S_SAVE_PTR: begin
        bus_rd = 1'b1; bus_addr = A_PTR; save_ptr = 1'b1;
        state_d = S_RD_STAT;
      end
      S_RD_STAT: begin
        bus_rd = 1'b1; bus_addr = A_STAT; save_cause = 1'b1;
        if (bus_rdata[0]) begin
          cause_in = 2'b01; state_d = S_RX_SVC;
        end else if (bus_rdata[1]) begin
          cause_in = 2'b10; state_d = S_TX_SVC;
        end else begin
          state_d = S_RST_ACK;
        end
      end
      S_RX_SVC, S_TX_SVC: begin
        if (!ety_done_q) begin
          ety_ret_d = state_q;
          state_d   = S_ETY_PTR;
        end else if (ety_err_q) begin
          state_d = S_RST_ACK;
        end else begin
          state_d = S_HI_PTR;
        end
      end
      S_ETY_PTR: begin
        bus_wr = 1'b1; bus_addr = A_PTR;
        bus_wdata = ptr_word(loc_rx, OFF_ETYPE);
        pf_start = 1'b1; pf_ret_d = S_ETY_DATA;
        state_d = S_PF_WAIT;
      end
      S_PF_WAIT: if (pf_done) state_d = pf_ret_q;
      S_ETY_DATA: begin
        bus_rd = 1'b1; bus_addr = A_DATA;
        ety_done_d = 1'b1;
        ety_err_d  = loc_bad;
        if (!loc_bad) off_d = loc_off;
        state_d = ety_ret_q;
      end
      S_HI_PTR: begin
        bus_wr = 1'b1; bus_addr = A_PTR;
        bus_wdata = ptr_word(dir_rx, off_q);
        pf_start = 1'b1; pf_ret_d = S_HI_RD;
        state_d = S_PF_WAIT;
      end
      S_HI_RD: begin
        bus_rd = 1'b1; bus_addr = A_DATA; hi_d = bus_rdata;
        state_d = S_LO_PTR;
      end
      S_LO_PTR: begin
        bus_wr = 1'b1; bus_addr = A_PTR;
        bus_wdata = ptr_word(dir_rx, off_q + 11'd2);
        pf_start = 1'b1; pf_ret_d = S_LO_RD;
        state_d = S_PF_WAIT;
      end
      S_LO_RD: begin
        bus_rd = 1'b1; bus_addr = A_DATA; lo_d = bus_rdata;
        state_d = S_LOOKUP;
      end
      S_LOOKUP: begin
        ip_valid = 1'b1;
        accept_d = dir_rx & trust_ok;
        state_d  = S_RST_ACK;
      end
      S_RST_ACK: begin
        bus_wr = 1'b1; bus_addr = A_STAT; bus_wdata = {14'b0, cause_q};
        state_d = S_RST_PTR;
      end
      S_RST_PTR: begin
        bus_wr = 1'b1; bus_addr = A_PTR; bus_wdata = ptr_q;
        state_d = S_RST_MASK;
      end
      S_RST_MASK: begin
        bus_wr = 1'b1; bus_addr = A_MASK; bus_wdata = mask_q;
        host_irq   = accept_q;
        ctx_clr    = 1'b1;
        ety_done_d = 1'b0;
        ety_err_d  = 1'b0;
        accept_d   = 1'b0;
        off_d      = '0;
        hi_d       = '0;
        lo_d       = '0;
        state_d    = S_IDLE;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= S_IDLE;
      pf_ret_q   <= S_IDLE;
      ety_ret_q  <= S_IDLE;
      ety_done_q <= 1'b0;
      ety_err_q  <= 1'b0;
      accept_q   <= 1'b0;
      off_q      <= '0;
      hi_q       <= '0;
      lo_q       <= '0;
    end else begin
      state_q    <= state_d;
      pf_ret_q   <= pf_ret_d;
      ety_ret_q  <= ety_ret_d;
      ety_done_q <= ety_done_d;
      ety_err_q  <= ety_err_d;
      accept_q   <= accept_d;
      off_q      <= off_d;
      hi_q       <= hi_d;
      lo_q       <= lo_d;
    end
  end

  assign ip_addr = {hi_q, lo_q};
  assign ip_off  = off_q;

  // cycles elapsed since the most recent pointer write, saturating
  logic [GW-1:0] gap_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q <= '0;
    end else if (bus_wr && bus_addr == A_PTR) begin
      gap_q <= GW'(1);
    end else if (gap_q != '0 && gap_q < GW'(GAP_LIM)) begin
      gap_q <= gap_q + 1'b1;
    end
  end

  AST_PREFETCH_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == A_DATA) |-> gap_q >= GW'(GAP_LIM)) else $error("data read too soon"); // R5
  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && bus_wr)) else $error("read and write together"); // R12
  AST_IRQ_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_IDLE && chip_irq) |=> (bus_rd && bus_addr == A_MASK)) else $error("entry not a mask read"); // R2
  AST_HOST_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    host_irq |=> !host_irq) else $error("host irq longer than one cycle"); // R10
  AST_HOST_WITH_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    host_irq |-> (bus_wr && bus_addr == A_MASK && cause_q == 2'b01)) else $error("host irq misplaced"); // R10
  AST_OFF_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    ip_valid |-> (ip_off == OFF_RX_IPV4 || ip_off == OFF_TX_IPV4 ||
                  ip_off == OFF_RX_ARP  || ip_off == OFF_TX_ARP)) else $error("illegal offset"); // R7
  AST_CLEARED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_MASK) |=> (ip_addr == '0 && ip_off == '0)) else $error("state not cleared"); // R11

endmodule

// File: tb/pkt_irq_seq_test.sv
module pkt_irq_seq_test;

  localparam int WAIT = 12;
  localparam logic [3:0] A_STAT = 4'd0, A_MASK = 4'd1, A_PTR = 4'd2, A_DATA = 4'd3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        chip_irq = 1'b0;
  logic [3:0]  bus_addr;
  logic        bus_rd, bus_wr;
  logic [15:0] bus_wdata, bus_rdata;
  logic [31:0] ip_addr;
  logic [10:0] ip_off;
  logic        ip_valid, trust_ok, host_irq;

  always #5 clk = ~clk;

  pkt_irq_seq #(.AW(4), .WAIT_CYC(WAIT)) uut (
    .clk(clk), .rst_n(rst_n), .chip_irq(chip_irq),
    .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ip_addr(ip_addr), .ip_off(ip_off), .ip_valid(ip_valid),
    .trust_ok(trust_ok), .host_irq(host_irq)
  );

  // ---------------- chip model ----------------
  logic [7:0]  rxf [48];
  logic [7:0]  txf [48];
  logic [15:0] chip_stat, chip_mask, chip_ptr;
  logic [31:0] trusted_ip;

  function automatic logic [15:0] frame_word(input logic [15:0] p);
    int o;
    o = int'(p[10:0]);
    if (o > 46) return 16'hBAD0;
    return p[15] ? {rxf[o], rxf[o+1]} : {txf[o], txf[o+1]};
  endfunction

  always_comb begin
    case (bus_addr)
      A_STAT:  bus_rdata = chip_stat;
      A_MASK:  bus_rdata = chip_mask;
      A_PTR:   bus_rdata = chip_ptr;
      A_DATA:  bus_rdata = frame_word(chip_ptr);
      default: bus_rdata = 16'h0000;
    endcase
  end

  assign trust_ok = (ip_addr == trusted_ip);

  logic        tb_load;
  logic [15:0] ld_stat, ld_mask, ld_ptr;
  always @(posedge clk) begin
    if (tb_load) begin
      chip_stat <= ld_stat; chip_mask <= ld_mask; chip_ptr <= ld_ptr;
    end else if (bus_wr) begin
      case (bus_addr)
        A_STAT:  chip_stat <= chip_stat & ~bus_wdata;
        A_MASK:  chip_mask <= bus_wdata;
        A_PTR:   chip_ptr  <= bus_wdata;
        default: ;
      endcase
    end
  end

  // ---------------- reference transaction model ----------------
  typedef struct {
    bit          wr;
    logic [3:0]  a;
    logic [15:0] d;
    bit          irq;
    string       req;
  } txn_t;

  txn_t  q[$];
  int    checks = 0;
  int    fails  = 0;
  int    cyc    = 0;
  int    last_ptr_cyc = -1000;
  bit    exp_ipv = 0;
  logic [31:0] exp_ip;
  logic [10:0] exp_off;
  bit    mon_on = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic push(input bit wr, input logic [3:0] a, input logic [15:0] d,
                      input bit irq, input string req);
    txn_t t;
    t.wr = wr; t.a = a; t.d = d; t.irq = irq; t.req = req;
    q.push_back(t);
  endtask

  always @(negedge clk) begin
    cyc++;
    if (mon_on) begin
      if (bus_rd && bus_wr) chk(0, "R12", "rd and wr together", 1, 0);
      if (ip_valid) begin
        chk(exp_ipv, "R8", "unexpected ip_valid", 1, {31'd0, exp_ipv});
        if (exp_ipv) begin
          chk(ip_addr == exp_ip, "R8", "ip_addr", ip_addr, exp_ip);
          chk(ip_off == exp_off, "R7", "ip_off", {21'd0, ip_off}, {21'd0, exp_off});
          exp_ipv = 0;
        end
      end
      if (bus_rd || bus_wr) begin
        if (q.size() == 0) begin
          chk(0, "R2", "unexpected bus access addr", {28'd0, bus_addr}, 0);
        end else begin
          txn_t t;
          t = q.pop_front();
          chk(bus_wr == t.wr, t.req, "access kind (1=write)", {31'd0, bus_wr}, {31'd0, t.wr});
          chk(bus_addr == t.a, t.req, "bus_addr", {28'd0, bus_addr}, {28'd0, t.a});
          if (t.wr) chk(bus_wdata == t.d, t.req, "bus_wdata", {16'd0, bus_wdata}, {16'd0, t.d});
          chk(host_irq == t.irq, "R10", "host_irq with access", {31'd0, host_irq}, {31'd0, t.irq});
          if (bus_rd && bus_addr == A_DATA)
            chk(cyc - last_ptr_cyc == WAIT + 1, "R5", "pointer-to-read gap",
                32'(cyc - last_ptr_cyc), 32'(WAIT + 1));
        end
        if (bus_wr && bus_addr == A_PTR) last_ptr_cyc = cyc;
      end else begin
        chk(!host_irq, "R10", "host_irq without access", {31'd0, host_irq}, 0);
      end
    end
  end

  task automatic fill_frames(input int seed, input logic [15:0] ety);
    for (int i = 0; i < 48; i++) begin
      rxf[i] = 8'(seed * 7 + i * 13 + 1);
      txf[i] = 8'(seed * 11 + i * 5 + 3);
    end
    rxf[12] = ety[15:8]; rxf[13] = ety[7:0];
    txf[12] = ety[15:8]; txf[13] = ety[7:0];
  endtask

  task automatic run_case(input int seed, input logic [15:0] stat,
                          input logic [15:0] ety, input bit trusted, input string req);
    bit rx, known;
    logic [1:0]  cause;
    logic [10:0] off;
    logic [15:0] m, p;
    int o;
    int guard;
    fill_frames(seed, ety);
    m = 16'h00A0 + 16'(seed);
    p = 16'h0400 + 16'(seed * 3);
    cause = stat[0] ? 2'b01 : (stat[1] ? 2'b10 : 2'b00);
    rx = cause[0];
    known = (ety == 16'h0800) || (ety == 16'h0806);
    if (ety == 16'h0800) off = rx ? 11'd26 : 11'd30;
    else                 off = rx ? 11'd28 : 11'd38;
    o = int'(off);
    exp_ip = rx ? {rxf[o], rxf[o+1], rxf[o+2], rxf[o+3]}
                : {txf[o], txf[o+1], txf[o+2], txf[o+3]};
    exp_off = off;
    trusted_ip = trusted ? exp_ip : ~exp_ip;

    push(0, A_MASK, 0, 0, "R2");
    push(1, A_MASK, 16'h0000, 0, "R2");
    push(0, A_PTR, 0, 0, "R2");
    push(0, A_STAT, 0, 0, "R2");
    if (cause != 2'b00) begin
      push(1, A_PTR, {rx, 4'b0, 11'd12}, 0, "R4");
      push(0, A_DATA, 0, 0, "R5");
      if (known) begin
        push(1, A_PTR, {rx, 4'b0, off}, 0, "R7");
        push(0, A_DATA, 0, 0, "R8");
        push(1, A_PTR, {rx, 4'b0, off + 11'd2}, 0, "R8");
        push(0, A_DATA, 0, 0, "R8");
        exp_ipv = 1;
      end
    end
    push(1, A_STAT, {14'b0, cause}, 0, "R9");
    push(1, A_PTR, p, 0, "R9");
    push(1, A_MASK, m, rx && known && trusted, "R9");

    @(negedge clk);
    ld_stat = stat; ld_mask = m; ld_ptr = p; tb_load = 1;
    @(negedge clk);
    tb_load = 0;
    chip_irq = 1;
    @(negedge clk);
    chip_irq = 0;
    guard = 0;
    while (q.size() != 0 && guard < 400) begin
      @(negedge clk);
      guard++;
    end
    repeat (4) @(negedge clk);
    chk(q.size() == 0, req, "accesses left undone", 32'(q.size()), 0);
    chk(!exp_ipv, "R6", "address strobe missing or extra", {31'd0, exp_ipv}, 0);
    chk(chip_mask == m, "R9", "mask restored", {16'd0, chip_mask}, {16'd0, m});
    chk(chip_ptr == p, "R9", "pointer restored", {16'd0, chip_ptr}, {16'd0, p});
    chk(chip_stat == (stat & ~{14'b0, cause}), "R3", "status after ack",
        {16'd0, chip_stat}, {16'd0, stat & ~{14'b0, cause}});
    chk(ip_addr == 0 && ip_off == 0, "R11", "address state cleared",
        ip_addr ^ {21'd0, ip_off}, 0);
    q.delete();
  endtask

  initial begin
    tb_load = 0; ld_stat = 0; ld_mask = 0; ld_ptr = 0; trusted_ip = 0;
    chip_stat = 0; chip_mask = 0; chip_ptr = 0;
    for (int i = 0; i < 48; i++) begin rxf[i] = 0; txf[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk(!bus_rd && !bus_wr, "R1", "bus idle after reset", {30'd0, bus_rd, bus_wr}, 0);
    chk(!host_irq && !ip_valid, "R1", "outputs low after reset", {30'd0, host_irq, ip_valid}, 0);
    mon_on = 1;
    repeat (3) @(negedge clk);

    run_case(1, 16'h0001, 16'h0800, 1, "R7");  // rx IPv4 trusted -> host irq
    run_case(2, 16'h0001, 16'h0800, 0, "R11"); // rx IPv4 untrusted, flag not sticky
    run_case(3, 16'h0002, 16'h0800, 1, "R10"); // tx IPv4, never host irq
    run_case(4, 16'h0001, 16'h0806, 1, "R7");  // rx ARP
    run_case(5, 16'h0002, 16'h0806, 0, "R7");  // tx ARP
    run_case(6, 16'h0001, 16'h86DD, 1, "R6");  // unknown type
    run_case(7, 16'h0002, 16'h1234, 1, "R6");  // unknown type on tx
    run_case(8, 16'h0000, 16'h0800, 1, "R3");  // no cause bit
    run_case(9, 16'h0003, 16'h0800, 1, "R3");  // both bits, rx first
    run_case(10, 16'h0002, 16'h0806, 1, "R3"); // leftover tx

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule